// File: doc/BRIEF.md
# Sigma-Delta Channel Interrupt Aggregator

This block merges the event conditions of four sigma-delta filter channels into a single CPU interrupt request. Each channel contributes four sources: a below-lower-limit comparator condition, an above-upper-limit comparator condition, a loss of the modulator bit clock, and a new-sample strobe from the main decimation filter. That makes sixteen sticky flags. Each flag has its own enable bit, and one global gate sits over all of them.

The filters and comparators are outside the block and arrive as plain level or strobe inputs. The block does its own clock-loss detection. Each channel's modulator clock passes through a two-stage synchronizer, and a counter restarts on every detected transition of that clock. When the counter reaches 64 system cycles with no transition, the channel's failure condition rises. It stays up until the next transition is seen.

Software writes the enable mask, the global gate and a clear mask through simple write strobes. A clear request only removes a flag when the source of that flag has gone quiet.

Top module: `sdint_aggregator`

## Requirements
- R1: The flag vector bit of channel c and event kind k is bit 4*c+k. The kind codes are: 0 = lower-limit comparator, 1 = upper-limit comparator, 2 = modulator clock failure, 3 = new data ready.
- R2: A high comparator input (lower or upper) sets its flag at the next rising clock edge.
- R3: A single-cycle data-ready strobe sets its flag, and the flag stays set after the strobe ends.
- R4: After reset, with a channel's modulator clock held still, that channel's failure flag is still clear after 64 clock edges and is set after edge 65.
- R5: Once the modulator clock toggles again, the failure condition drops and the flag becomes clearable.
- R6: Flags are sticky: once a flag is set, removing its source does not clear it.
- R7: A clear write removes each flag whose mask bit is 1 and whose source is inactive. Mask bits of 0 leave their flags untouched.
- R8: A clear of a flag whose source is active leaves the flag set. A set and a clear in the same cycle leave the flag set.
- R9: irq_o is high exactly when the global gate is 1 and at least one flag has its enable bit at 1. The enable and gate registers load on their write strobes.
- R10: summary_o always equals irq_o.
- R11: Synchronous active-high reset zeroes all flags, the enables, the gate and the clock-loss counters, so irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_lo_i | input | 4 | Per-channel lower-limit comparator level |
| cmp_hi_i | input | 4 | Per-channel upper-limit comparator level |
| data_rdy_i | input | 4 | Per-channel new-sample strobe |
| mod_clk_i | input | 4 | Per-channel modulator bit clock (asynchronous) |
| en_wr_i | input | 1 | Load strobe for the enable mask |
| en_data_i | input | 16 | Enable mask value |
| master_wr_i | input | 1 | Load strobe for the global gate |
| master_data_i | input | 1 | Global gate value |
| clr_wr_i | input | 1 | Clear request strobe |
| clr_data_i | input | 16 | Clear mask, 1 = clear that flag |
| irq_o | output | 1 | Combined interrupt request |
| flags_o | output | 16 | Sticky flag vector |
| summary_o | output | 1 | Copy of the interrupt state |

## Verification
The two functions that can land in the same cycle are the setting of a flag by its source and a software clear of that flag. The bench provokes this in two ways. It issues a clear while a comparator level or a stalled modulator clock is still asserting the source. It also raises a one-cycle data-ready strobe in the very cycle of a clear write. In both cases it judges the flag vector at the next falling edge, where the flag must be set. A second overlap is a clock transition that arrives while the failure condition is up. This is judged by whether a later clear succeeds.

// File: rtl/sdint_pkg.sv
package sdint_pkg;

    localparam int NUM_CH     = 4;
    localparam int KINDS      = 4;
    localparam int NUM_SRC    = NUM_CH * KINDS;
    localparam int LOSS_LIMIT = 64;

    // event kind code = bit offset inside a channel's group of flags
    typedef enum logic [1:0] {
        EV_LOW     = 2'd0,
        EV_HIGH    = 2'd1,
        EV_MODFAIL = 2'd2,
        EV_DRDY    = 2'd3
    } ev_kind_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic     wr;
        src_vec_t mask;
    } mask_wr_t;

    function automatic int src_index(input int ch, input ev_kind_e kind);
        return ch * KINDS + int'(kind);
    endfunction

endpackage

// File: rtl/sdint_clk_watch.sv
module sdint_clk_watch #(
    parameter int LIMIT       = sdint_pkg::LOSS_LIMIT,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mod_clk,
    output logic tgl_o,
    output logic fail_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    // stages 0..SYNC_STAGES-1 synchronize, the last one keeps history
    logic [SYNC_STAGES:0] shr;
    logic [CW-1:0]        quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst) shr <= '0;
        else     shr <= {shr[SYNC_STAGES-1:0], mod_clk};
    end

    assign tgl_o = shr[SYNC_STAGES] ^ shr[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst)                  quiet_cnt <= '0;
        else if (tgl_o)           quiet_cnt <= '0;
        else if (quiet_cnt != LIM) quiet_cnt <= quiet_cnt + 1'b1;
    end

    assign fail_o = (quiet_cnt == LIM);

endmodule

// File: rtl/sdint_flag_bank.sv
module sdint_flag_bank #(
    parameter int N = sdint_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_i,
    input  logic         clr_wr_i,
    input  logic [N-1:0] clr_mask_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] clr_eff;
    logic [N-1:0] flags_n;

    assign clr_eff = clr_wr_i ? clr_mask_i : '0;

    // an active source re-asserts its flag, which both blocks a clear and wins a tie
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            assign flags_n[i] = src_i[i] | (flags_o[i] & ~clr_eff[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= flags_n;
    end

endmodule

// File: rtl/sdint_irq_gate.sv
module sdint_irq_gate #(
    parameter int N = sdint_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] flags_i,
    input  logic         en_wr_i,
    input  logic [N-1:0] en_data_i,
    input  logic         master_wr_i,
    input  logic         master_data_i,
    output logic         master_o,
    output logic         irq_o
);
    logic [N-1:0] en_q;
    logic         master_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            master_q <= 1'b0;
        end else begin
            if (en_wr_i)     en_q     <= en_data_i;
            if (master_wr_i) master_q <= master_data_i;
        end
    end

    assign master_o = master_q;
    assign irq_o    = master_q & (|(flags_i & en_q));

endmodule

// File: rtl/sdint_aggregator.sv
module sdint_aggregator
    import sdint_pkg::*;
#(
    parameter int CH    = NUM_CH,
    parameter int LIMIT = LOSS_LIMIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CH-1:0]     cmp_lo_i,
    input  logic [CH-1:0]     cmp_hi_i,
    input  logic [CH-1:0]     data_rdy_i,
    input  logic [CH-1:0]     mod_clk_i,
    input  logic              en_wr_i,
    input  logic [CH*KINDS-1:0] en_data_i,
    input  logic              master_wr_i,
    input  logic              master_data_i,
    input  logic              clr_wr_i,
    input  logic [CH*KINDS-1:0] clr_data_i,
    output logic              irq_o,
    output logic [CH*KINDS-1:0] flags_o,
    output logic              summary_o
);
    localparam int NS = CH * KINDS;

    logic [NS-1:0] src_vec;
    logic [CH-1:0] tgl_vec;
    logic [CH-1:0] fail_vec;
    logic          master_en;
    mask_wr_t      clr_req;

    generate
        for (genvar c = 0; c < CH; c++) begin : g_ch
            sdint_clk_watch #(.LIMIT(LIMIT), .SYNC_STAGES(2)) i_watch (
                .clk     (clk),
                .rst     (rst),
                .mod_clk (mod_clk_i[c]),
                .tgl_o   (tgl_vec[c]),
                .fail_o  (fail_vec[c])
            );
            assign src_vec[src_index(c, EV_LOW)]     = cmp_lo_i[c];
            assign src_vec[src_index(c, EV_HIGH)]    = cmp_hi_i[c];
            assign src_vec[src_index(c, EV_MODFAIL)] = fail_vec[c];
            assign src_vec[src_index(c, EV_DRDY)]    = data_rdy_i[c];
        end
    endgenerate

    assign clr_req = '{wr: clr_wr_i, mask: clr_data_i};

    sdint_flag_bank #(.N(NS)) i_flags (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src_vec),
        .clr_wr_i   (clr_req.wr),
        .clr_mask_i (clr_req.mask),
        .flags_o    (flags_o)
    );

    sdint_irq_gate #(.N(NS)) i_gate (
        .clk           (clk),
        .rst           (rst),
        .flags_i       (flags_o),
        .en_wr_i       (en_wr_i),
        .en_data_i     (en_data_i),
        .master_wr_i   (master_wr_i),
        .master_data_i (master_data_i),
        .master_o      (master_en),
        .irq_o         (irq_o)
    );

    assign summary_o = irq_o;

endmodule

// File: rtl/sdint_aggregator_chk.sv
module sdint_aggregator_chk #(
    parameter int CH = 4,
    parameter int NS = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [NS-1:0] src,
    input logic [NS-1:0] flags,
    input logic          clr_wr,
    input logic [NS-1:0] clr_mask,
    input logic [CH-1:0] tgl,
    input logic [CH-1:0] fail,
    input logic          master,
    input logic          irq
);
    // R2 / R3: a flag only rises where its source was active
    p_set_needs_src_r2: assert property (@(posedge clk) disable iff (rst)
        (flags & ~$past(flags) & ~$past(src)) == '0);

    // R8: a set flag whose source is active cannot be cleared
    p_active_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (flags & $past(flags & src)) == $past(flags & src));

    // R7: a flag only falls under a clear request for that bit
    p_clear_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
        (~flags & $past(flags) & ~$past(clr_wr ? clr_mask : '0)) == '0);

    // R4: failure condition never rises right after a seen clock transition
    p_fail_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (fail & ~$past(fail) & $past(tgl)) == '0);

    // R5: a transition while failed drops the failure condition
    p_fail_drops_r5: assert property (@(posedge clk) disable iff (rst)
        (fail & $past(fail & tgl)) == '0);

    // R9: the interrupt needs the gate and some flag
    p_irq_needs_gate_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (master && (flags != '0)));

endmodule

bind sdint_aggregator sdint_aggregator_chk #(.CH(CH), .NS(CH*4)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .src      (src_vec),
    .flags    (flags_o),
    .clr_wr   (clr_wr_i),
    .clr_mask (clr_data_i),
    .tgl      (tgl_vec),
    .fail     (fail_vec),
    .master   (master_en),
    .irq      (irq_o)
);

// File: tb/test_sdint_aggregator.sv
`timescale 1ns/1ps
module test_sdint_aggregator;
    localparam int NCH = 4;
    localparam int NS  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NCH-1:0] cmp_lo = '0, cmp_hi = '0, drdy = '0, mod_clk = '0;
    logic          en_wr = 1'b0, master_wr = 1'b0, master_data = 1'b0, clr_wr = 1'b0;
    logic [NS-1:0] en_data = '0, clr_data = '0;
    logic          irq, summary;
    logic [NS-1:0] flags;

    logic [NCH-1:0] mrun = '0;
    int phase = 0;
    int checks = 0;
    int errors = 0;

    sdint_aggregator i_sdint_aggregator (
        .clk(clk), .rst(rst), .cmp_lo_i(cmp_lo), .cmp_hi_i(cmp_hi),
        .data_rdy_i(drdy), .mod_clk_i(mod_clk), .en_wr_i(en_wr),
        .en_data_i(en_data), .master_wr_i(master_wr), .master_data_i(master_data),
        .clr_wr_i(clr_wr), .clr_data_i(clr_data), .irq_o(irq),
        .flags_o(flags), .summary_o(summary)
    );

    always #2 clk = ~clk;

    // modulator clock model: toggles every 3 cycles, stops low when halted
    always @(negedge clk) begin
        phase <= phase + 1;
        for (int c = 0; c < NCH; c++) begin
            if (!mrun[c])          mod_clk[c] <= 1'b0;
            else if (phase % 3 == 0) mod_clk[c] <= ~mod_clk[c];
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_en(input logic [NS-1:0] v);
        en_wr = 1'b1; en_data = v; tick(); en_wr = 1'b0;
    endtask

    task automatic wr_master(input logic v);
        master_wr = 1'b1; master_data = v; tick(); master_wr = 1'b0;
    endtask

    task automatic wr_clr(input logic [NS-1:0] v);
        clr_wr = 1'b1; clr_data = v; tick(); clr_wr = 1'b0; clr_data = '0;
    endtask

    task automatic set_src(input int idx, input logic v);
        int c, k;
        c = idx / 4;
        k = idx % 4;
        case (k)
            0: cmp_lo[c] = v;
            1: cmp_hi[c] = v;
            2: mrun[c]   = ~v;
            default: drdy[c] = v;
        endcase
    endtask

    task automatic wait_src(input int idx, input bit rising);
        if (idx % 4 == 2) repeat (rising ? 75 : 14) tick();
        else tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [NS-1:0] bit_m;
        // clocks held still through reset for the exact loss-window test
        rst = 1'b1;
        repeat (5) tick();
        rst = 1'b0;
        chk("R11 flags after reset", 32'(flags), 32'h0);
        chk("R11 irq after reset", 32'(irq), 32'h0);
        repeat (64) tick();
        chk("R4 no failure after 64 quiet edges", 32'(flags), 32'h0);
        tick();
        chk("R4 R1 failure flags at edge 65", 32'(flags), 32'h4444);
        chk("R11 R9 gate still off", 32'(irq), 32'h0);
        chk("R10 summary mirrors irq", 32'(summary), 32'(irq));

        mrun = '1;
        repeat (14) tick();
        wr_clr('1);
        chk("R5 failure clearable after clock resumes", 32'(flags), 32'h0);

        // sweep every source
        for (int idx = 0; idx < NS; idx++) begin
            bit_m = NS'(1) << idx;
            wr_en(bit_m);
            wr_master(1'b1);
            set_src(idx, 1'b1);
            wait_src(idx, 1'b1);
            chk($sformatf("R1 R2 set flag %0d", idx), 32'(flags), 32'(bit_m));
            chk($sformatf("R9 irq on flag %0d", idx), 32'(irq), 32'h1);
            chk($sformatf("R10 summary flag %0d", idx), 32'(summary), 32'h1);
            wr_clr(bit_m);
            chk($sformatf("R8 clear blocked flag %0d", idx), 32'(flags), 32'(bit_m));
            set_src(idx, 1'b0);
            wait_src(idx, 1'b0);
            chk($sformatf("R6 sticky flag %0d", idx), 32'(flags), 32'(bit_m));
            wr_master(1'b0);
            chk($sformatf("R9 gate off flag %0d", idx), 32'(irq), 32'h0);
            wr_master(1'b1);
            wr_en(~bit_m);
            chk($sformatf("R9 other enables flag %0d", idx), 32'(irq), 32'h0);
            wr_en(bit_m);
            wr_clr(~bit_m);
            chk($sformatf("R7 zero mask keeps flag %0d", idx), 32'(flags), 32'(bit_m));
            wr_clr(bit_m);
            chk($sformatf("R7 clear flag %0d", idx), 32'(flags), 32'h0);
            chk($sformatf("R9 irq drops flag %0d", idx), 32'(irq), 32'h0);
        end

        // R3: one-cycle data-ready strobe on channel 2 (bit 11)
        drdy[2] = 1'b1; tick(); drdy[2] = 1'b0;
        tick(); tick();
        chk("R3 strobe keeps flag 11", 32'(flags), 32'h800);
        wr_clr(16'h0800);

        // R8: strobe and clear in the same cycle, channel 0 data ready (bit 3)
        drdy[0] = 1'b1; clr_wr = 1'b1; clr_data = 16'h0008;
        tick();
        drdy[0] = 1'b0; clr_wr = 1'b0; clr_data = '0;
        chk("R8 set wins over same-cycle clear", 32'(flags), 32'h0008);
        wr_clr(16'h0008);
        chk("R7 clear after tie", 32'(flags), 32'h0);

        // R2 R9: comparator pattern, irq follows enable overlap arithmetically
        cmp_lo = 4'b0101; cmp_hi = 4'b1010; tick();
        cmp_lo = '0; cmp_hi = '0;
        chk("R2 comparator pattern", 32'(flags), 32'h2121 | 32'h0202 ^ 32'h0202 | 32'h2121);
        for (int e = 0; e < NS; e++) begin
            wr_en(NS'(1) << e);
            chk($sformatf("R9 enable sweep bit %0d", e), 32'(irq),
                32'((32'h2121 >> e) & 1));
        end
        wr_clr('1);
        chk("R7 full clear", 32'(flags), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule